// File: doc/BRIEF.md
# Clock-Synthesizer Programming Sequencer

This block sits on the host side of a serially programmed frequency synthesizer. It takes one configuration request over a valid/ready handshake. A request holds a feedback (VCO) divider word, a reference divider word, an output divide select, a secondary-output function, a duty-level bit and a crystal load-capacitance code. The block checks that both divider words are legal and packs the fields into a 24-bit serial frame. It then drives the three programming pins (serial clock, serial data and load strobe) with timing taken from a system clock.

The minimum data setup before each serial clock edge is a parameter counted in system-clock cycles, rounded up to a whole cycle. The same holds for the hold after the edge, the gap before the strobe and the strobe width. The load strobe stays low for the whole shift and is pulsed only after the last bit. After the strobe falls, the block waits out a programmable lock interval before it reports completion. A request with an illegal divider word is refused: the error flag is raised, the pins stay idle and the sequencer stays ready for the next request.

Top module: `clksyn_prog_seq`

## Requirements
- R1: `req_ready_o` is high exactly when the sequencer is idle. A legal request presented with `req_valid_i` high while ready is accepted at that clock edge, and `busy_o` is high from the next cycle until the transfer completes.
- R2: A request is illegal when the VCO word is below 4 or the reference word is 0. An illegal request accepted while ready sets `err_o` high from the next cycle. It causes no activity on `sclk_o` or `strobe_o`, leaves `busy_o` low and keeps `req_ready_o` high.
- R3: Accepting a legal request clears `err_o` from the next cycle.
- R4: Exactly 24 bits are shifted, most significant first, from the frame {cap[1:0], duty, clk2_fn[1:0], div_sel[2:0], vco[8:0], ref[6:0]}. The first bit is cap[1] and the last is ref[0].
- R5: Each bit is on `sdata_o`, unchanged, for exactly SETUP_CYC cycles with `sclk_o` low before `sclk_o` rises.
- R6: `sclk_o` stays high for exactly HOLD_CYC cycles per bit, and `sdata_o` does not change while it is high.
- R7: `strobe_o` is low throughout the shift. It rises exactly WAIT_CYC cycles after the last fall of `sclk_o`, and `sclk_o` is never high together with `strobe_o`.
- R8: `strobe_o` is high for exactly STROBE_CYC cycles.
- R9: `done_o` is a one-cycle pulse. It is raised LOCK_CYC cycles after `strobe_o` falls, on the same edge that `busy_o` falls.
- R10: Requests presented while busy are ignored: the frame being shifted is unchanged and no second transfer follows.
- R11: During reset `sclk_o`, `sdata_o`, `strobe_o`, `busy_o`, `done_o` and `err_o` are low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_vco_i | input | 9 | VCO feedback divider word |
| req_ref_i | input | 7 | Reference divider word |
| req_div_sel_i | input | 3 | Output divide select code |
| req_clk2_fn_i | input | 2 | Secondary-output function code |
| req_duty_i | input | 1 | Duty-cycle level bit |
| req_cap_i | input | 2 | Crystal load-capacitance code |
| busy_o | output | 1 | Transfer or lock wait in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last accepted request was illegal |
| sclk_o | output | 1 | Serial clock to the synthesizer |
| sdata_o | output | 1 | Serial data to the synthesizer |
| strobe_o | output | 1 | Load strobe to the synthesizer |

## Verification
All pin outputs are registered. Every result therefore appears one clock after the edge that causes it: acceptance raises `busy_o` and shows the first bit on the following cycle, and an illegal request raises `err_o` one cycle after it is taken. A monitor samples the pins on every falling clock edge and measures the length of each phase in samples. It compares each setup, high, wait, strobe and lock run with the exact parameter count, and it compares the total busy length with 24*(SETUP_CYC+HOLD_CYC)+WAIT_CYC+STROBE_CYC+LOCK_CYC. The driver reads the collected results one time step after the falling edge where `done_o` is seen, and then checks one cycle later that the pulse has ended.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;

  localparam int VCO_W   = 9;
  localparam int REF_W   = 7;
  localparam int FRAME_W = 24;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_WAIT,
    ST_STROBE,
    ST_LOCK
  } seq_state_e;

  // Packed in shift order: the most significant bit leaves first.
  typedef struct packed {
    logic [1:0]       cap;
    logic             duty;
    logic [1:0]       clk2_fn;
    logic [2:0]       div_sel;
    logic [VCO_W-1:0] vco_div;
    logic [REF_W-1:0] ref_div;
  } prog_req_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/clksyn_req_check.sv
module clksyn_req_check
  import clksyn_pkg::*;
#(
  parameter int VCO_MIN = 4,
  parameter int REF_MIN = 1
) (
  input  prog_req_t            req_i,
  output logic                 legal_o,
  output logic [FRAME_W-1:0]   frame_o
);

  localparam logic [VCO_W-1:0] VCO_LO = VCO_W'(VCO_MIN);
  localparam logic [REF_W-1:0] REF_LO = REF_W'(REF_MIN);

  always_comb begin
    legal_o = (req_i.vco_div >= VCO_LO) && (req_i.ref_div >= REF_LO);
    frame_o = {req_i.cap, req_i.duty, req_i.clk2_fn, req_i.div_sel,
               req_i.vco_div, req_i.ref_div};
  end

endmodule

// File: rtl/clksyn_phase_timer.sv
module clksyn_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/clksyn_shifter.sv
module clksyn_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] din_i,
  output logic         msb_next_o,
  output logic         last_bit_o
);

  localparam int BIT_W = $clog2(W);

  logic [W-1:0]     sh_q, sh_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             sh_en;

  always_comb begin
    sh_en = load_i || shift_i;
    sh_d  = load_i ? din_i : {sh_q[W-2:0], 1'b0};
    bit_d = load_i ? '0 : bit_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= '0;
    end else if (sh_en) begin
      sh_q  <= sh_d;
      bit_q <= bit_d;
    end
  end

  assign msb_next_o = sh_en ? sh_d[W-1] : sh_q[W-1];
  assign last_bit_o = (bit_q == BIT_W'(W-1));

endmodule

// File: rtl/clksyn_prog_seq.sv
module clksyn_prog_seq
  import clksyn_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int HOLD_CYC   = 2,
  parameter int WAIT_CYC   = 2,
  parameter int STROBE_CYC = 5,
  parameter int LOCK_CYC   = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid_i,
  output logic       req_ready_o,
  input  logic [8:0] req_vco_i,
  input  logic [6:0] req_ref_i,
  input  logic [2:0] req_div_sel_i,
  input  logic [1:0] req_clk2_fn_i,
  input  logic       req_duty_i,
  input  logic [1:0] req_cap_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic       sclk_o,
  output logic       sdata_o,
  output logic       strobe_o
);

  localparam int MAX_CYC = max_of(max_of(max_of(SETUP_CYC, HOLD_CYC),
                                         max_of(WAIT_CYC, STROBE_CYC)), LOCK_CYC);
  localparam int CNT_W   = max_of($clog2(MAX_CYC + 1), 1);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  prog_req_t          req;
  logic               legal;
  logic [FRAME_W-1:0] frame;

  assign req = '{cap: req_cap_i, duty: req_duty_i, clk2_fn: req_clk2_fn_i,
                 div_sel: req_div_sel_i, vco_div: req_vco_i, ref_div: req_ref_i};

  clksyn_req_check #(.VCO_MIN(4), .REF_MIN(1)) u_check (
    .req_i   (req),
    .legal_o (legal),
    .frame_o (frame)
  );

  seq_state_e       state_q, state_d;
  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift, msb_next, last_bit;
  logic             err_en, err_d, err_q, done_d, done_q;
  logic             sclk_d, sdata_d, strobe_d;
  logic             sclk_q, sdata_q, strobe_q;

  clksyn_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  clksyn_shifter #(.W(FRAME_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (sh_load),
    .shift_i    (sh_shift),
    .din_i      (frame),
    .msb_next_o (msb_next),
    .last_bit_o (last_bit)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    err_en   = 1'b0;
    err_d    = err_q;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        err_en = 1'b1;
        err_d  = !legal;
        if (legal) begin
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(SETUP_CYC - 1);
          sh_load  = 1'b1;
        end
      end
      ST_SETUP: if (tmr_expired) begin
        state_d  = ST_HIGH;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(HOLD_CYC - 1);
      end
      ST_HIGH: if (tmr_expired) begin
        tmr_load = 1'b1;
        if (last_bit) begin
          state_d = ST_WAIT;
          tmr_val = CNT_W'(WAIT_CYC - 1);
        end else begin
          state_d  = ST_SETUP;
          tmr_val  = CNT_W'(SETUP_CYC - 1);
          sh_shift = 1'b1;
        end
      end
      ST_WAIT: if (tmr_expired) begin
        state_d  = ST_STROBE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(STROBE_CYC - 1);
      end
      ST_STROBE: if (tmr_expired) begin
        state_d  = ST_LOCK;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(LOCK_CYC - 1);
      end
      ST_LOCK: if (tmr_expired) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    sclk_d   = (state_d == ST_HIGH);
    strobe_d = (state_d == ST_STROBE);
    sdata_d  = ((state_d == ST_SETUP) || (state_d == ST_HIGH)) && msb_next;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      done_q   <= 1'b0;
      sclk_q   <= 1'b0;
      sdata_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      done_q   <= done_d;
      sclk_q   <= sclk_d;
      sdata_q  <= sdata_d;
      strobe_q <= strobe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  err_q <= 1'b0;
    else if (err_en)  err_q <= err_d;
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign sclk_o      = sclk_q;
  assign sdata_o     = sdata_q;
  assign strobe_o    = strobe_q;

endmodule

module clksyn_prog_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic [8:0] req_vco_i,
  input logic [6:0] req_ref_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       sclk_o,
  input logic       sdata_o,
  input logic       strobe_o
);

  logic req_ok, take;
  assign req_ok = (req_vco_i >= 9'd4) && (req_ref_i != 7'd0);
  assign take   = req_valid_i && req_ready_o;

  a_r1_accept_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_ok |=> busy_o);

  a_r2_illegal_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    take && !req_ok |=> !busy_o && err_o && req_ready_o);

  a_r3_legal_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_ok |=> !err_o);

  a_r6_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o && $past(sclk_o) |-> $stable(sdata_o));

  a_r7_strobe_excludes_sclk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> !sclk_o);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !busy_o && $past(busy_o));

  a_r10_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !req_ready_o);

  a_r11_pins_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sclk_o && !strobe_o);

endmodule

bind clksyn_prog_seq clksyn_prog_seq_chk u_chk (.*);

// File: tb/clksyn_prog_seq_tb.sv
module clksyn_prog_seq_tb_top;

  localparam int S_CYC = 2;
  localparam int H_CYC = 3;
  localparam int W_CYC = 2;
  localparam int T_CYC = 4;
  localparam int L_CYC = 20;
  localparam int BUSY_LEN = 24 * (S_CYC + H_CYC) + W_CYC + T_CYC + L_CYC;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid_i;
  logic       req_ready_o;
  logic [8:0] req_vco_i;
  logic [6:0] req_ref_i;
  logic [2:0] req_div_sel_i;
  logic [1:0] req_clk2_fn_i;
  logic       req_duty_i;
  logic [1:0] req_cap_i;
  logic       busy_o, done_o, err_o, sclk_o, sdata_o, strobe_o;

  always #4 clk = ~clk;

  clksyn_prog_seq #(
    .SETUP_CYC(S_CYC), .HOLD_CYC(H_CYC), .WAIT_CYC(W_CYC),
    .STROBE_CYC(T_CYC), .LOCK_CYC(L_CYC)
  ) dut_i (.*);

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_frame(input logic [8:0] v, input logic [6:0] r,
      input logic [2:0] d, input logic [1:0] f, input logic u, input logic [1:0] c);
    return {c, u, f, d, v, r};
  endfunction

  // Pin monitor, sampled on falling edges.
  int nbits, low_len, high_len, bad_setup, bad_hold, bad_data, stb_early;
  int wait_len, stb_len, lock_len, done_len, busy_len;
  bit stb_seen, prev_busy, prev_sclk, lo_val, hi_val;
  logic [23:0] frame_cap;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_busy = 1'b0;
      prev_sclk = 1'b0;
    end else begin
      if (busy_o && !prev_busy) begin
        nbits = 0; frame_cap = '0; low_len = 1; high_len = 0; lo_val = sdata_o;
        bad_setup = 0; bad_hold = 0; bad_data = 0; stb_early = 0; wait_len = 0;
        stb_len = 0; lock_len = 0; done_len = 0; stb_seen = 1'b0; busy_len = 1;
      end else begin
        if (busy_o) busy_len++;
        if (sclk_o && !prev_sclk) begin
          frame_cap = {frame_cap[22:0], sdata_o};
          nbits++;
          if (low_len != S_CYC) bad_setup++;
          high_len = 1;
          hi_val = sdata_o;
        end else if (sclk_o) begin
          high_len++;
          if (sdata_o != hi_val) bad_data++;
        end else if (prev_sclk) begin
          if (high_len != H_CYC) bad_hold++;
          low_len = 1;
          lo_val = sdata_o;
          if (nbits == 24 && !strobe_o) wait_len++;
        end else if (busy_o && nbits < 24) begin
          low_len++;
          if (sdata_o != lo_val) bad_data++;
        end else if (busy_o && nbits == 24 && !strobe_o && !stb_seen) begin
          wait_len++;
        end
      end
      if (strobe_o) begin
        stb_seen = 1'b1;
        stb_len++;
        if (nbits < 24) stb_early++;
      end else if (stb_seen && busy_o) begin
        lock_len++;
      end
      if (done_o) done_len++;
      prev_busy = busy_o;
      prev_sclk = sclk_o;
    end
  end

  task automatic drive_req(input logic [8:0] v, input logic [6:0] r, input logic [2:0] d,
                           input logic [1:0] f, input logic u, input logic [1:0] c);
    @(negedge clk);
    req_vco_i = v; req_ref_i = r; req_div_sel_i = d;
    req_clk2_fn_i = f; req_duty_i = u; req_cap_i = c;
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic run_legal(input logic [8:0] v, input logic [6:0] r, input logic [2:0] d,
                           input logic [1:0] f, input logic u, input logic [1:0] c,
                           input bit poke);
    logic [23:0] exp;
    int guard;
    exp = exp_frame(v, r, d, f, u, c);
    drive_req(v, r, d, f, u, c);
    #1;
    check(busy_o && !req_ready_o, "R1", "busy after accept", busy_o, 1);
    if (poke) begin
      // R10: another request while busy must be ignored
      repeat (10) @(negedge clk);
      req_vco_i = ~v; req_ref_i = ~r; req_cap_i = ~c; req_valid_i = 1'b1;
      repeat (4) @(negedge clk);
      req_valid_i = 1'b0;
    end
    guard = 0;
    do begin
      @(negedge clk); #1;
      guard++;
    end while (!done_o && guard < 2000);
    check(done_o == 1'b1, "R9", "done seen", done_o, 1);
    check(frame_cap == exp, poke ? "R10" : "R4", "shifted frame", frame_cap, exp);
    check(nbits == 24, "R4", "bit count", nbits, 24);
    check(bad_setup == 0, "R5", "setup runs off", bad_setup, 0);
    check(bad_hold == 0 && bad_data == 0, "R6", "hold or data change", bad_hold + bad_data, 0);
    check(wait_len == W_CYC && stb_early == 0, "R7", "wait before strobe", wait_len, W_CYC);
    check(stb_len == T_CYC, "R8", "strobe width", stb_len, T_CYC);
    check(lock_len == L_CYC, "R9", "lock wait", lock_len, L_CYC);
    check(busy_len == BUSY_LEN && !busy_o, "R9", "busy length", busy_len, BUSY_LEN);
    check(err_o == 1'b0, "R3", "err after legal", err_o, 0);
    @(negedge clk); #1;
    check(!done_o && done_len == 1, "R9", "done width", done_len, 1);
    check(req_ready_o && !busy_o, poke ? "R10" : "R1", "idle after done", busy_o, 0);
  endtask

  task automatic run_illegal(input logic [8:0] v, input logic [6:0] r);
    int act;
    drive_req(v, r, 3'd5, 2'd1, 1'b1, 2'd3);
    #1;
    check(err_o == 1'b1, "R2", "err after illegal", err_o, 1);
    act = 0;
    repeat (20) begin
      @(negedge clk); #1;
      if (busy_o || sclk_o || strobe_o || !req_ready_o) act++;
    end
    check(act == 0, "R2", "pin activity after illegal", act, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    req_valid_i = 1'b0;
    req_vco_i = '0; req_ref_i = '0; req_div_sel_i = '0;
    req_clk2_fn_i = '0; req_duty_i = 1'b0; req_cap_i = '0;
    repeat (4) @(negedge clk);
    #1;
    check({sclk_o, sdata_o, strobe_o, busy_o, done_o, err_o} == 6'b0, "R11",
          "outputs in reset", {sclk_o, sdata_o, strobe_o, busy_o, done_o, err_o}, 0);
    check(req_ready_o == 1'b1, "R11", "ready in reset", req_ready_o, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Directed corners
    run_legal(9'd4, 7'd1, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0);        // R4 minimum words
    run_legal(9'd511, 7'd127, 3'd7, 2'd3, 1'b1, 2'd3, 1'b0);    // R4 all ones
    run_illegal(9'd3, 7'd1);                                    // R2 vco just below range
    run_legal(9'h155, 7'h2A, 3'd5, 2'd2, 1'b0, 2'd2, 1'b1);     // R3 clears err, R10 poke
    run_illegal(9'd4, 7'd0);                                    // R2 ref zero
    run_illegal(9'd0, 7'd0);                                    // R2 both illegal
    run_legal(9'h0AA, 7'h55, 3'd2, 2'd1, 1'b1, 2'd1, 1'b0);

    // Constrained random mix
    for (int i = 0; i < 30; i++) begin
      logic [8:0] v;
      logic [6:0] r;
      if ($urandom_range(4) == 0) begin
        v = 9'($urandom_range(3));
        r = 7'($urandom_range(127));
        if ($urandom_range(1) == 1) begin
          v = 9'($urandom_range(511, 4));
          r = 7'd0;
        end
        run_illegal(v, r);
      end else begin
        v = 9'($urandom_range(511, 4));
        r = 7'($urandom_range(127, 1));
        run_legal(v, r, 3'($urandom_range(7)), 2'($urandom_range(3)),
                  1'($urandom_range(1)), 2'($urandom_range(3)), ($urandom_range(3) == 0));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule